// File: doc/BRIEF.md
# Chip-Select Matcher with Rank Sparing

This block decides which of eight DRAM chip-selects answers a normalized controller input address. Each chip-select has a raw base register, a raw mask register and a bank-enable bit. A format selector picks one of two register layouts. Each layout clears the unused base fields and forces the don't-care mask fields before the compare. The older layout also moves the address four bits to the left before the compare. When several enabled windows cover the address, the lowest-numbered chip-select is reported.

A rank can be retired onto a spare by giving the matcher a failing-rank number and a replacement-rank number. A lookup that resolves to the failing rank then reports the replacement rank instead. The replacement's own window is not changed by this. If the replacement number names no chip-select, an error flag is raised and the original rank is kept. The result is registered, so it appears one cycle after the request.

Top module: `cssel_matcher`

## Requirements
- R1: Chip-select i matches only when cs_en[i] is 1 and (A AND NOT M) equals (B AND NOT M), where A is the compare address and B and M are the normalized base and mask of chip-select i. Base i occupies cs_base[32*i+31:32*i], and mask i occupies the same bits of cs_mask.
- R2: When more than one chip-select matches, the lowest index is reported.
- R3: With fmt_new=1, B = base AND 0x1FF83FE0, M = (mask OR 0x0007C01F) AND 0x1FFFFFFF, and A = req_addr.
- R4: With fmt_new=0, B = base AND 0xFFE0FE00, M = (mask OR 0x001F01FF) AND 0x3FFFFFFF, and A = req_addr shifted left by 4 and truncated to 32 bits.
- R5: Sparing is off when bad_rank and spare_rank are both 4'hF. In that case no redirect happens and rsp_spare_err stays 0.
- R6: When sparing is on and the matched index equals bad_rank, rsp_cs reports spare_rank. A lookup that matches the spare's own window reports the spare index as usual.
- R7: When a redirect is required and spare_rank is not below 8, rsp_spare_err is 1, rsp_hit is 1 and rsp_cs keeps the matched index.
- R8: When no chip-select matches, rsp_miss is 1, rsp_hit is 0, rsp_cs is 0 and rsp_spare_err is 0.
- R9: The outputs for a request with req_valid=1 appear in the next cycle, with rsp_valid=1. After a cycle without a request, rsp_valid is 0 and all other outputs are 0.
- R10: Synchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Normalized controller input address |
| fmt_new | input | 1 | 1 = newer register layout, 0 = older layout |
| cs_base | input | 256 | Raw base registers, eight 32-bit fields |
| cs_mask | input | 256 | Raw mask registers, eight 32-bit fields |
| cs_en | input | 8 | Bank-enable bit per chip-select |
| bad_rank | input | 4 | Failing rank number, 4'hF = none |
| spare_rank | input | 4 | Replacement rank number, 4'hF = none |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A chip-select responded |
| rsp_miss | output | 1 | No chip-select responded |
| rsp_cs | output | 3 | Responding chip-select after sparing |
| rsp_spare_err | output | 1 | Redirect needed but the replacement rank does not exist |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid pipeline;
- that hit and miss are mutually exclusive;
- the zero index and clear error on a miss;
- that all outputs are quiet after an idle cycle;
- that a request with every bank disabled misses;
- that the error flag never rises while sparing is off or the replacement rank exists;
- that a valid, distinct failing rank is never reported.

Other behaviour only the bench scenarios can show. This covers which chip-select wins for a given address, the field masking of each register layout, the address shift of the older layout, and the exact redirected index. The bench compares each of these against an independent reference computed from the requirements.

// File: rtl/cssel_pkg.sv
package cssel_pkg;

    localparam int ADDR_W = 32;
    localparam int RANK_W = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [RANK_W-1:0] rank_t;

    localparam rank_t RANK_NONE = '1;

    // Newer register layout field constants
    localparam addr_t NEW_BASE_KEEP = 32'h1FF8_3FE0;
    localparam addr_t NEW_MASK_SET  = 32'h0007_C01F;
    localparam addr_t NEW_MASK_KEEP = 32'h1FFF_FFFF;

    // Older register layout field constants
    localparam addr_t OLD_BASE_KEEP = 32'hFFE0_FE00;
    localparam addr_t OLD_MASK_SET  = 32'h001F_01FF;
    localparam addr_t OLD_MASK_KEEP = 32'h3FFF_FFFF;
    localparam int    OLD_ADDR_SHL  = 4;

    typedef enum logic {
        FMT_OLD = 1'b0,
        FMT_NEW = 1'b1
    } reg_fmt_e;

    // A compare window: bits that must match, and the value they must hold
    typedef struct packed {
        addr_t care;
        addr_t value;
    } cs_win_t;

    typedef struct packed {
        logic hit;
        logic miss;
        logic err;
    } res_flags_t;

    function automatic cs_win_t make_window(reg_fmt_e fmt, addr_t raw_base, addr_t raw_mask);
        cs_win_t w;
        addr_t   b;
        addr_t   m;
        if (fmt == FMT_NEW) begin
            b = raw_base & NEW_BASE_KEEP;
            m = (raw_mask | NEW_MASK_SET) & NEW_MASK_KEEP;
        end else begin
            b = raw_base & OLD_BASE_KEEP;
            m = (raw_mask | OLD_MASK_SET) & OLD_MASK_KEEP;
        end
        w.care  = ~m;
        w.value = b & ~m;
        return w;
    endfunction

    function automatic addr_t cmp_address(reg_fmt_e fmt, addr_t a);
        return (fmt == FMT_NEW) ? a : (a << OLD_ADDR_SHL);
    endfunction

endpackage

// File: rtl/cssel_window.sv
module cssel_window
    import cssel_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  reg_fmt_e                 fmt,
    input  addr_t                    addr,
    input  logic [NUM_CS*ADDR_W-1:0] base_flat,
    input  logic [NUM_CS*ADDR_W-1:0] mask_flat,
    input  logic [NUM_CS-1:0]        en,
    output logic [NUM_CS-1:0]        hit_vec
);

    addr_t cmp_a;
    assign cmp_a = cmp_address(fmt, addr);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        cs_win_t win;
        assign win = make_window(fmt,
                                 base_flat[g*ADDR_W +: ADDR_W],
                                 mask_flat[g*ADDR_W +: ADDR_W]);
        assign hit_vec[g] = en[g] && ((cmp_a & win.care) == win.value);
    end

endmodule

// File: rtl/cssel_prio.sv
module cssel_prio #(
    parameter int NUM_CS = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CS-1:0] hit_vec,
    output logic              any_hit,
    output logic [IDX_W-1:0]  first_idx
);

    // Scan from the top down so the lowest index is written last and wins
    always_comb begin
        first_idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IDX_W'(i);
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/cssel_spare.sv
module cssel_spare
    import cssel_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int IDX_W  = 3
) (
    input  logic             any_hit,
    input  logic [IDX_W-1:0] first_idx,
    input  rank_t            bad_rank,
    input  rank_t            spare_rank,
    output res_flags_t       flags,
    output logic [IDX_W-1:0] out_idx
);

    localparam rank_t CS_COUNT = RANK_W'(NUM_CS);

    logic spare_on;
    logic redirect;
    logic spare_exists;

    assign spare_on     = !((bad_rank == RANK_NONE) && (spare_rank == RANK_NONE));
    assign redirect     = any_hit && spare_on && (RANK_W'(first_idx) == bad_rank);
    assign spare_exists = spare_rank < CS_COUNT;

    always_comb begin
        flags.hit  = any_hit;
        flags.miss = !any_hit;
        flags.err  = redirect && !spare_exists;
        if (!any_hit)
            out_idx = '0;
        else if (redirect && spare_exists)
            out_idx = spare_rank[IDX_W-1:0];
        else
            out_idx = first_idx;
    end

endmodule

// File: rtl/cssel_matcher.sv
module cssel_matcher
    import cssel_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     fmt_new,
    input  logic [NUM_CS*ADDR_W-1:0] cs_base,
    input  logic [NUM_CS*ADDR_W-1:0] cs_mask,
    input  logic [NUM_CS-1:0]        cs_en,
    input  logic [RANK_W-1:0]        bad_rank,
    input  logic [RANK_W-1:0]        spare_rank,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic [IDX_W-1:0]         rsp_cs,
    output logic                     rsp_spare_err
);

    reg_fmt_e          fmt;
    logic [NUM_CS-1:0] hit_vec;
    logic              any_hit;
    logic [IDX_W-1:0]  first_idx;
    res_flags_t        flags_d, flags_q;
    logic [IDX_W-1:0]  idx_d, idx_q;
    logic              valid_q;

    assign fmt = fmt_new ? FMT_NEW : FMT_OLD;

    cssel_window #(.NUM_CS(NUM_CS)) window_i (
        .fmt       (fmt),
        .addr      (req_addr),
        .base_flat (cs_base),
        .mask_flat (cs_mask),
        .en        (cs_en),
        .hit_vec   (hit_vec)
    );

    cssel_prio #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) prio_i (
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    cssel_spare #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) spare_i (
        .any_hit    (any_hit),
        .first_idx  (first_idx),
        .bad_rank   (bad_rank),
        .spare_rank (spare_rank),
        .flags      (flags_d),
        .out_idx    (idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                flags_q <= flags_d;
                idx_q   <= idx_d;
            end else begin
                flags_q <= '0;
                idx_q   <= '0;
            end
        end
    end

    assign rsp_valid     = valid_q;
    assign rsp_hit       = flags_q.hit;
    assign rsp_miss      = flags_q.miss;
    assign rsp_spare_err = flags_q.err;
    assign rsp_cs        = idx_q;

endmodule

// File: rtl/cssel_matcher_chk.sv
module cssel_matcher_chk #(
    parameter int NUM_CS = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [NUM_CS-1:0] cs_en,
    input logic [3:0]        bad_rank,
    input logic [3:0]        spare_rank,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [IDX_W-1:0]  rsp_cs,
    input logic              rsp_spare_err
);

    localparam logic [3:0] NONE_R  = 4'hF;
    localparam logic [3:0] COUNT_R = 4'(NUM_CS);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_spare_err && rsp_cs == '0));

    a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    a_r8_miss_clean: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_cs == '0 && !rsp_spare_err));

    a_r1_all_disabled_miss: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cs_en == '0) |=> rsp_miss);

    a_r5_off_no_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_rank == NONE_R && spare_rank == NONE_R) |=> !rsp_spare_err);

    a_r7_err_with_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_spare_err |-> rsp_hit);

    a_r7_no_err_spare_exists: assert property (@(posedge clk) disable iff (rst)
        (req_valid && spare_rank < COUNT_R) |=> !rsp_spare_err);

    a_r6_bad_never_reported: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bad_rank < COUNT_R && spare_rank < COUNT_R && bad_rank != spare_rank)
        |=> !(rsp_hit && 4'(rsp_cs) == $past(bad_rank)));

endmodule

bind cssel_matcher cssel_matcher_chk #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .cs_en         (cs_en),
    .bad_rank      (bad_rank),
    .spare_rank    (spare_rank),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_cs        (rsp_cs),
    .rsp_spare_err (rsp_spare_err)
);

// File: tb/cssel_matcher_tb_top.sv
module cssel_matcher_tb_top;

    localparam int N = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              fmt_new = 1'b1;
    logic [N*32-1:0]   cs_base;
    logic [N*32-1:0]   cs_mask;
    logic [N-1:0]      cs_en = '1;
    logic [3:0]        bad_rank = 4'hF;
    logic [3:0]        spare_rank = 4'hF;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_spare_err;
    logic [2:0]        rsp_cs;

    logic [31:0] base_r [N];
    logic [31:0] mask_r [N];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cs_base[i*32 +: 32] = base_r[i];
            cs_mask[i*32 +: 32] = mask_r[i];
        end
    end

    cssel_matcher dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .fmt_new(fmt_new), .cs_base(cs_base), .cs_mask(cs_mask), .cs_en(cs_en),
        .bad_rank(bad_rank), .spare_rank(spare_rank),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_cs(rsp_cs), .rsp_spare_err(rsp_spare_err)
    );

    typedef struct {
        logic        hit;
        logic        miss;
        logic        err;
        logic [2:0]  idx;
        int          stamp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   nvec = 0;
    int   nfail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference built from the requirements
    function automatic exp_t model(logic [31:0] a_in, string tag);
        exp_t e;
        logic [31:0] a, b, m;
        int   found;
        bit   on;
        found = -1;
        a = fmt_new ? a_in : (a_in << 4);
        for (int i = 0; i < N; i++) begin
            if (fmt_new) begin
                b = base_r[i] & 32'h1FF83FE0;
                m = (mask_r[i] | 32'h0007C01F) & 32'h1FFFFFFF;
            end else begin
                b = base_r[i] & 32'hFFE0FE00;
                m = (mask_r[i] | 32'h001F01FF) & 32'h3FFFFFFF;
            end
            if (found < 0 && cs_en[i] && ((a & ~m) == (b & ~m))) found = i;
        end
        e.tag = tag;
        e.stamp = cyc;
        e.err = 0;
        if (found < 0) begin
            e.hit = 0; e.miss = 1; e.idx = 0;
        end else begin
            e.hit = 1; e.miss = 0; e.idx = 3'(found);
            on = !(bad_rank == 4'hF && spare_rank == 4'hF);
            if (on && found == int'(bad_rank)) begin
                if (spare_rank < 4'd8) e.idx = spare_rank[2:0];
                else e.err = 1;
            end
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        sb_q.push_back(model(a, tag));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result with the oldest expected item
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            exp_t e;
            nvec++;
            if (sb_q.size() == 0) begin
                nfail++;
                $display("FAIL R9 unexpected result: actual rsp_valid=1 expected rsp_valid=0");
            end else begin
                e = sb_q.pop_front();
                if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_spare_err !== e.err ||
                    rsp_cs !== e.idx || cyc != e.stamp + 1) begin
                    nfail++;
                    $display("FAIL %s: actual hit=%0b miss=%0b err=%0b cs=%0d cyc=%0d expected hit=%0b miss=%0b err=%0b cs=%0d cyc=%0d",
                             e.tag, rsp_hit, rsp_miss, rsp_spare_err, rsp_cs, cyc,
                             e.hit, e.miss, e.err, e.idx, e.stamp + 1);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL R9 watchdog: actual run still busy expected finished");
            summary();
            $finish;
        end
    end

    task automatic cfg_new();
        fmt_new = 1'b1;
        for (int i = 0; i < N; i++) begin
            base_r[i] = 32'(i) << 24;
            mask_r[i] = 32'h00FF_FFFF;
        end
        cs_en = '1; bad_rank = 4'hF; spare_rank = 4'hF;
    endtask

    task automatic cfg_old();
        fmt_new = 1'b0;
        for (int i = 0; i < N; i++) begin
            base_r[i] = 32'(i) << 25;
            mask_r[i] = 32'h01FF_FFFF;
        end
        cs_en = '1; bad_rank = 4'hF; spare_rank = 4'hF;
    endtask

    initial begin
        logic [31:0] lcg;
        cfg_new();
        repeat (3) @(negedge clk);
        // R10: reset state
        nvec++;
        if (rsp_valid || rsp_hit || rsp_miss || rsp_spare_err || rsp_cs != 0) begin
            nfail++;
            $display("FAIL R10 reset: actual v=%0b h=%0b m=%0b e=%0b cs=%0d expected all 0",
                     rsp_valid, rsp_hit, rsp_miss, rsp_spare_err, rsp_cs);
        end
        @(negedge clk); rst = 1'b0;

        // R1 / R3: basic windows in the newer layout, back-to-back (R9)
        send(32'h0312_3456, "R1 cs3 hit");
        send(32'h0000_0010, "R1 cs0 hit");
        send(32'h07FF_FFFF, "R3 top of cs7");
        send(32'h0800_0000, "R8 above all windows");
        idle(2);
        // R3: forced/cleared fields
        base_r[2] = 32'hE200_001F;
        mask_r[4] = 32'h0;
        send(32'h0200_0000, "R3 base fields cleared");
        send(32'h0400_401F, "R3 forced mask bits");
        send(32'h0400_0020, "R3 compared bit differs");
        send(32'h2100_0000, "R3 top bits compared");
        idle(1);
        // R2: overlap
        cfg_new();
        base_r[5] = 32'h0100_0000;
        send(32'h0100_0abc, "R2 lowest index wins");
        idle(1);
        // R1: disabled bank
        cs_en[3] = 1'b0;
        send(32'h0300_0000, "R1 disabled cs3 misses");
        idle(1);
        cs_en = '0;
        send(32'h0100_0000, "R1 all disabled");
        idle(1);
        // R6 / R5 / R7: sparing
        cfg_new();
        bad_rank = 4'd2; spare_rank = 4'd6;
        send(32'h0200_1000, "R6 redirect cs2 to cs6");
        send(32'h0600_1000, "R6 spare window unchanged");
        send(32'h0100_1000, "R6 other rank untouched");
        idle(1);
        bad_rank = 4'd2; spare_rank = 4'hF;
        send(32'h0200_1000, "R7 spare missing (none code)");
        idle(1);
        bad_rank = 4'd2; spare_rank = 4'd9;
        send(32'h0200_1000, "R7 spare number out of range");
        send(32'h0800_0000, "R8 miss while sparing set");
        idle(1);
        bad_rank = 4'hF; spare_rank = 4'hF;
        send(32'h0200_1000, "R5 sparing off");
        idle(1);
        bad_rank = 4'hF; spare_rank = 4'd4;
        send(32'h0200_1000, "R5 no bad rank named");
        idle(1);
        // R4: older layout
        cfg_old();
        send(32'h0060_0000, "R4 cs3 after shift");
        send(32'h001F_FFF0, "R4 cs0 top");
        send(32'h1060_0000, "R4 shifted-out bits ignored");
        idle(1);
        base_r[7] = 32'hC000_0000; mask_r[7] = 32'hFFFF_FFFF;
        send(32'h0C00_0000, "R4 mask top bits cleared");
        idle(1);
        // Sweeps over both layouts with gaps (R9)
        cfg_new();
        bad_rank = 4'd5; spare_rank = 4'd1;
        lcg = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send(lcg & 32'h0FFF_FFFF, "R1 sweep new layout");
            if (k % 7 == 0) idle(1);
        end
        idle(1);
        cfg_old();
        bad_rank = 4'd3; spare_rank = 4'hE;
        for (int k = 0; k < 40; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send(lcg & 32'h01FF_FFFF, "R4 sweep old layout");
        end
        idle(3);
        if (sb_q.size() != 0) begin
            nfail++;
            $display("FAIL R9 lost results: actual %0d pending expected 0", sb_q.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule